// File: doc/BRIEF.md
# Shuffle-Linked Delta Interconnection Network

This block connects N = 2^LOG_N requesting processor ports to N memory ports through LOG_N columns of two-input, two-output arbitrating switches. Adjacent columns are joined by fixed perfect-shuffle wiring. A requester presents a request flag, a LOG_N-bit memory index and an information bundle. The bundle carries the address, write data and the read/write flag, and its packing is opaque to the network. Each switch steers a request with one bit of its memory index. When two requests want the same switch output, one passes and the other is rejected. A rejected request comes back as busy. No switch holds any state.

The network is synchronous. All requesters present their requests at the same cycle boundary, where an input register captures them. The network is combinational from that register to the memory ports. The memory's busy flag and read data travel back along the same path, and a second register captures them. A requester that sees busy keeps its request high to try again. The next attempt is decided with no memory of the previous one.

Top module: `delta_net`

## Requirements
- R1: While rst_ni is low, and after it is released until the first request is captured, busy_o, rdata_o and mem_req_o are all zero.
- R2: req_i, dest_i and info_i are sampled at a rising clk_i edge and appear at the memory ports in the following cycle. busy_o and rdata_o for that request are captured one edge later, together with mem_busy_i and mem_rdata_i as seen in that cycle.
- R3: Column c (0 = next to the requesters) steers by dest bit LOG_N-1-c. A 0 selects the upper output, which is the even line of the switch, and a 1 selects the odd line. Column output line j feeds next-column input line (2j + floor(2j/N)) mod N. A request that is never rejected reaches mem_req_o[dest], and its info sits on the mem_info_o slice for that port.
- R4: When both inputs of a switch request the same output, one input always wins. In column 0 the even input wins. In later columns, switch m (inputs 2m and 2m+1) favours input 2m + (m mod 2).
- R5: busy_o[k] is 1 exactly when requester k requested and was rejected at some switch, or reached a memory port whose mem_busy_i was 1. A requester with no request sees busy_o[k] = 0.
- R6: For a requester that no switch rejected, rdata_o[k] equals the mem_rdata_i slice of its destination port in the cycle its request was at the memory.
- R7: Each memory port receives at most one request, and mem_req_o never has more bits set than there are captured requests.
- R8: The permutation dest = rotate-right-by-one of the requester index, with every requester active, is conflict free: all busy_o bits are 0 when memory is idle.
- R9: A lone request reaches any destination from any requester with busy_o = 0 when memory is idle.
- R10: A cycle's arbitration depends only on that cycle's requests. A request rejected in one cycle gets through in the next if its competitor withdraws.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request flag per requester |
| dest_i | input | N*LOG_N | Memory index per requester, requester k at bits k*LOG_N |
| info_i | input | N*INFO_W | Information bundle per requester |
| busy_o | output | N | Rejected or memory busy, per requester |
| rdata_o | output | N*RDATA_W | Read data returned per requester |
| mem_req_o | output | N | Request arriving at each memory port |
| mem_info_o | output | N*INFO_W | Information bundle at each memory port |
| mem_busy_i | input | N | Busy flag from each memory port |
| mem_rdata_i | input | N*RDATA_W | Read data from each memory port |

## Verification
The switches hold no state, so a wrong steering bit, wrong shuffle index or wrong priority choice shows at the memory ports in the cycle after capture. It appears there as a request on the wrong port or with another requester's bundle. The same fault shows as a wrong busy_o bit or wrong read data one edge later. Sweeping every request mask against every common destination exposes the priority order of every switch in every column. Random patterns with random memory busy cover the path back to the requesters.

// File: rtl/delta_pkg.sv
package delta_pkg;

  // perfect shuffle of 2^lg lines: one-bit left rotation of the line index
  function automatic int unsigned shuffle_line(int unsigned j, int unsigned lg);
    int unsigned n;
    n = 32'd1 << lg;
    return ((j << 1) | (j >> (lg - 1))) & (n - 1);
  endfunction

endpackage

// File: rtl/delta_switch.sv
module delta_switch #(
  parameter int unsigned DW = 3,
  parameter int unsigned IW = 8,
  parameter int unsigned RW = 8,
  parameter bit          HI = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      in_req_i,
  input  logic [1:0]      in_bit_i,
  input  logic [2*DW-1:0] in_dest_i,
  input  logic [2*IW-1:0] in_info_i,
  output logic [1:0]      out_req_o,
  output logic [2*DW-1:0] out_dest_o,
  output logic [2*IW-1:0] out_info_o,
  input  logic [1:0]      out_busy_i,
  input  logic [2*RW-1:0] out_rdata_i,
  output logic [1:0]      in_busy_o,
  output logic [2*RW-1:0] in_rdata_o
);
  localparam int unsigned HP = HI ? 1 : 0;
  localparam int unsigned LP = 1 - HP;

  logic       clash;
  logic [1:0] grant;

  assign clash     = in_req_i[HP] & in_req_i[LP] & (in_bit_i[HP] == in_bit_i[LP]);
  assign grant[HP] = in_req_i[HP];
  assign grant[LP] = in_req_i[LP] & ~clash;

  for (genvar o = 0; o < 2; o++) begin : g_out
    logic take_hi, take_lo;
    assign take_hi = grant[HP] & (in_bit_i[HP] == 1'(o));
    assign take_lo = grant[LP] & (in_bit_i[LP] == 1'(o));
    assign out_req_o[o] = take_hi | take_lo;
    assign out_dest_o[o*DW +: DW] = take_hi ? in_dest_i[HP*DW +: DW] : in_dest_i[LP*DW +: DW];
    assign out_info_o[o*IW +: IW] = take_hi ? in_info_i[HP*IW +: IW] : in_info_i[LP*IW +: IW];
  end

  for (genvar p = 0; p < 2; p++) begin : g_back
    assign in_busy_o[p] = in_req_i[p] & (~grant[p] | out_busy_i[in_bit_i[p]]);
    assign in_rdata_o[p*RW +: RW] = grant[p] ? out_rdata_i[in_bit_i[p]*RW +: RW] : '0;
  end

  // R4: every request either leaves on an output or is rejected here
  a_r4_conserve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(out_req_o) + $countones(in_req_i & ~grant) == $countones(in_req_i));

  // R4: the favoured input is never rejected locally
  a_r4_hi_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_req_i[HP] && !out_busy_i[in_bit_i[HP]]) |-> !in_busy_o[HP]);

endmodule

// File: rtl/delta_stage.sv
module delta_stage #(
  parameter int unsigned LOG_N = 3,
  parameter int unsigned IW    = 8,
  parameter int unsigned RW    = 8,
  parameter int unsigned STAGE = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         in_req_i,
  input  logic [N*LOG_N-1:0]   in_dest_i,
  input  logic [N*IW-1:0]      in_info_i,
  output logic [N-1:0]         out_req_o,
  output logic [N*LOG_N-1:0]   out_dest_o,
  output logic [N*IW-1:0]      out_info_o,
  input  logic [N-1:0]         out_busy_i,
  input  logic [N*RW-1:0]      out_rdata_i,
  output logic [N-1:0]         in_busy_o,
  output logic [N*RW-1:0]      in_rdata_o
);
  localparam int unsigned N   = 1 << LOG_N;
  localparam int unsigned BIT = LOG_N - 1 - STAGE;

  for (genvar m = 0; m < N/2; m++) begin : g_sw
    // column 0 favours even inputs; later columns alternate by switch parity
    localparam bit HI = (STAGE != 0) && (m % 2 == 1);
    logic [1:0] steer;
    assign steer = {in_dest_i[(2*m+1)*LOG_N + BIT], in_dest_i[2*m*LOG_N + BIT]};

    delta_switch #(.DW(LOG_N), .IW(IW), .RW(RW), .HI(HI)) u_sw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_req_i   (in_req_i[2*m +: 2]),
      .in_bit_i   (steer),
      .in_dest_i  (in_dest_i[2*m*LOG_N +: 2*LOG_N]),
      .in_info_i  (in_info_i[2*m*IW +: 2*IW]),
      .out_req_o  (out_req_o[2*m +: 2]),
      .out_dest_o (out_dest_o[2*m*LOG_N +: 2*LOG_N]),
      .out_info_o (out_info_o[2*m*IW +: 2*IW]),
      .out_busy_i (out_busy_i[2*m +: 2]),
      .out_rdata_i(out_rdata_i[2*m*RW +: 2*RW]),
      .in_busy_o  (in_busy_o[2*m +: 2]),
      .in_rdata_o (in_rdata_o[2*m*RW +: 2*RW])
    );
  end

endmodule

// File: rtl/delta_net.sv
module delta_net #(
  parameter int unsigned LOG_N   = 3,
  parameter int unsigned INFO_W  = 8,
  parameter int unsigned RDATA_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [(1<<LOG_N)-1:0]          req_i,
  input  logic [(1<<LOG_N)*LOG_N-1:0]    dest_i,
  input  logic [(1<<LOG_N)*INFO_W-1:0]   info_i,
  output logic [(1<<LOG_N)-1:0]          busy_o,
  output logic [(1<<LOG_N)*RDATA_W-1:0]  rdata_o,
  output logic [(1<<LOG_N)-1:0]          mem_req_o,
  output logic [(1<<LOG_N)*INFO_W-1:0]   mem_info_o,
  input  logic [(1<<LOG_N)-1:0]          mem_busy_i,
  input  logic [(1<<LOG_N)*RDATA_W-1:0]  mem_rdata_i
);
  localparam int unsigned N  = 1 << LOG_N;
  localparam int unsigned DW = LOG_N;
  localparam int unsigned IW = INFO_W;
  localparam int unsigned RW = RDATA_W;

  logic [N-1:0]    req_q, busy_q;
  logic [N*DW-1:0] dest_q;
  logic [N*IW-1:0] info_q;
  logic [N*RW-1:0] rdata_q;

  // level s = inputs of column s; level LOG_N = memory ports
  logic [LOG_N:0][N-1:0]    lv_req, lv_busy;
  logic [LOG_N:0][N*DW-1:0] lv_dest;
  logic [LOG_N:0][N*IW-1:0] lv_info;
  logic [LOG_N:0][N*RW-1:0] lv_rdata;
  // column outputs before the shuffle
  logic [LOG_N-1:0][N-1:0]    so_req, so_busy;
  logic [LOG_N-1:0][N*DW-1:0] so_dest;
  logic [LOG_N-1:0][N*IW-1:0] so_info;
  logic [LOG_N-1:0][N*RW-1:0] so_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= '0;
      dest_q  <= '0;
      info_q  <= '0;
      busy_q  <= '0;
      rdata_q <= '0;
    end else begin
      req_q   <= req_i;
      dest_q  <= dest_i;
      info_q  <= info_i;
      busy_q  <= lv_busy[0];
      rdata_q <= lv_rdata[0];
    end
  end

  assign lv_req[0]       = req_q;
  assign lv_dest[0]      = dest_q;
  assign lv_info[0]      = info_q;
  assign lv_busy[LOG_N]  = mem_busy_i;
  assign lv_rdata[LOG_N] = mem_rdata_i;

  for (genvar s = 0; s < LOG_N; s++) begin : g_col
    delta_stage #(.LOG_N(LOG_N), .IW(IW), .RW(RW), .STAGE(s)) u_col (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_req_i   (lv_req[s]),
      .in_dest_i  (lv_dest[s]),
      .in_info_i  (lv_info[s]),
      .out_req_o  (so_req[s]),
      .out_dest_o (so_dest[s]),
      .out_info_o (so_info[s]),
      .out_busy_i (so_busy[s]),
      .out_rdata_i(so_rdata[s]),
      .in_busy_o  (lv_busy[s]),
      .in_rdata_o (lv_rdata[s])
    );

    for (genvar j = 0; j < N; j++) begin : g_link
      // last column feeds the memory ports directly
      localparam int unsigned K = (s == LOG_N-1) ? j : delta_pkg::shuffle_line(j, LOG_N);
      assign lv_req[s+1][K]           = so_req[s][j];
      assign lv_dest[s+1][K*DW +: DW] = so_dest[s][j*DW +: DW];
      assign lv_info[s+1][K*IW +: IW] = so_info[s][j*IW +: IW];
      assign so_busy[s][j]            = lv_busy[s+1][K];
      assign so_rdata[s][j*RW +: RW]  = lv_rdata[s+1][K*RW +: RW];
    end
  end

  assign mem_req_o  = lv_req[LOG_N];
  assign mem_info_o = lv_info[LOG_N];
  assign busy_o     = busy_q;
  assign rdata_o    = rdata_q;

  for (genvar d = 0; d < N; d++) begin : g_chk
    // R3: whatever lands on port d carries index d
    a_r3_lands_on_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o[d] |-> lv_dest[LOG_N][d*DW +: DW] == DW'(d));
    // R5: no request, no busy
    a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_q[d] |=> !busy_o[d]);
  end

  a_r7_no_excess: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mem_req_o) <= $countones(req_q));

  a_r5_all_mem_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mem_busy_i) |=> (busy_o == $past(req_q)));

  a_r9_lone_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(req_q) == 1 && mem_busy_i == '0) |=> (busy_o == '0));

endmodule

// File: tb/delta_net_tb_top.sv
module delta_net_tb_top;
  localparam int LOG_N = 3;
  localparam int N     = 1 << LOG_N;
  localparam int IW    = 8;
  localparam int RW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]       req_i, busy_o, mem_req_o, mem_busy_i;
  logic [N*LOG_N-1:0] dest_i;
  logic [N*IW-1:0]    info_i, mem_info_o;
  logic [N*RW-1:0]    rdata_o, mem_rdata_i;

  delta_net #(.LOG_N(LOG_N), .INFO_W(IW), .RDATA_W(RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .dest_i(dest_i), .info_i(info_i),
    .busy_o(busy_o), .rdata_o(rdata_o), .mem_req_o(mem_req_o), .mem_info_o(mem_info_o),
    .mem_busy_i(mem_busy_i), .mem_rdata_i(mem_rdata_i)
  );

  // memory model: read data derived from the arriving bundle and port index
  function automatic logic [RW-1:0] mem_fn(logic [IW-1:0] inf, int d);
    return RW'(inf) ^ RW'(8'h5A + d);
  endfunction

  always_comb
    for (int d = 0; d < N; d++) mem_rdata_i[d*RW +: RW] = mem_fn(mem_info_o[d*IW +: IW], d);

  int n_run = 0, n_fail = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pattern being built, current expectation, previous expectation
  logic [N-1:0]       p_req, p_mask, c_mask, pv_mask;
  logic [LOG_N-1:0]   p_dest [N];
  logic [IW-1:0]      p_info [N];
  logic [N-1:0]       e_mreq, e_blk, e_req, pv_blk, pv_req;
  logic [IW-1:0]      e_minfo [N];
  logic [LOG_N-1:0]   e_dest [N], pv_dest [N];
  logic [IW-1:0]      e_info [N], pv_info [N];

  task automatic model();
    bit lreq [N]; int lsrc [N];
    bit nreq [N]; int nsrc [N];
    for (int l = 0; l < N; l++) begin lreq[l] = p_req[l]; lsrc[l] = l; end
    e_blk = '0;
    for (int s = 0; s < LOG_N; s++) begin
      for (int l = 0; l < N; l++) begin nreq[l] = 0; nsrc[l] = 0; end
      for (int m = 0; m < N/2; m++) begin
        int hi, a, b; bit ba, bb;
        hi = (s == 0) ? 0 : (m % 2);
        a = 2*m + hi; b = 2*m + 1 - hi;
        ba = p_dest[lsrc[a]][LOG_N-1-s];
        bb = p_dest[lsrc[b]][LOG_N-1-s];
        if (lreq[a]) begin nreq[2*m + int'(ba)] = 1; nsrc[2*m + int'(ba)] = lsrc[a]; end
        if (lreq[b]) begin
          if (lreq[a] && ba == bb) e_blk[lsrc[b]] = 1'b1;
          else begin nreq[2*m + int'(bb)] = 1; nsrc[2*m + int'(bb)] = lsrc[b]; end
        end
      end
      for (int j = 0; j < N; j++) begin
        int k;
        k = (s < LOG_N-1) ? (2*j + j/(N/2)) % N : j;
        lreq[k] = nreq[j]; lsrc[k] = nsrc[j];
      end
    end
    for (int d = 0; d < N; d++) begin
      e_mreq[d]  = lreq[d];
      e_minfo[d] = lreq[d] ? p_info[lsrc[d]] : '0;
    end
    e_req = p_req;
    for (int k = 0; k < N; k++) begin e_dest[k] = p_dest[k]; e_info[k] = p_info[k]; end
  endtask

  task automatic apply();
    logic [N-1:0] eb;
    @(negedge clk);
    pv_blk = e_blk; pv_req = e_req; pv_mask = c_mask;
    for (int k = 0; k < N; k++) begin pv_dest[k] = e_dest[k]; pv_info[k] = e_info[k]; end
    model();
    c_mask = p_mask;
    req_i = p_req;
    for (int k = 0; k < N; k++) begin
      dest_i[k*LOG_N +: LOG_N] = p_dest[k];
      info_i[k*IW +: IW]       = p_info[k];
    end
    mem_busy_i = pv_mask;
    @(posedge clk); #1;
    chk(mem_req_o === e_mreq, "R3/R7 mem_req_o", 64'(mem_req_o), 64'(e_mreq));
    for (int d = 0; d < N; d++)
      if (e_mreq[d])
        chk(mem_info_o[d*IW +: IW] === e_minfo[d], "R3 mem_info_o", 64'(mem_info_o[d*IW +: IW]), 64'(e_minfo[d]));
    for (int k = 0; k < N; k++) eb[k] = pv_req[k] & (pv_blk[k] | pv_mask[pv_dest[k]]);
    chk(busy_o === eb, "R4/R5 busy_o", 64'(busy_o), 64'(eb));
    for (int k = 0; k < N; k++)
      if (pv_req[k] && !pv_blk[k])
        chk(rdata_o[k*RW +: RW] === mem_fn(pv_info[k], int'(pv_dest[k])), "R6 rdata_o",
            64'(rdata_o[k*RW +: RW]), 64'(mem_fn(pv_info[k], int'(pv_dest[k]))));
  endtask

  task automatic idle_pat();
    p_req = '0; p_mask = '0;
    for (int k = 0; k < N; k++) begin p_dest[k] = '0; p_info[k] = '0; end
  endtask

  task automatic rand_info();
    for (int k = 0; k < N; k++) begin rng = nxt(rng); p_info[k] = rng[IW-1:0]; end
  endtask

  initial begin
    req_i = '0; dest_i = '0; info_i = '0; mem_busy_i = '0;
    e_blk = '0; e_req = '0; e_mreq = '0; c_mask = '0;
    for (int k = 0; k < N; k++) begin e_dest[k] = '0; e_info[k] = '0; e_minfo[k] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk(busy_o == '0 && rdata_o == '0 && mem_req_o == '0, "R1 in reset", 64'(busy_o), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    #1 chk(busy_o == '0 && rdata_o == '0 && mem_req_o == '0, "R1 after release", 64'(mem_req_o), 64'(0));

    // R2: latency through the two registers
    @(negedge clk);
    req_i = 8'b0000_1000; dest_i[3*LOG_N +: LOG_N] = 3'd5; info_i[3*IW +: IW] = 8'hC3;
    #1 chk(mem_req_o == '0, "R2 before capture", 64'(mem_req_o), 64'(0));
    @(posedge clk); #1;
    chk(mem_req_o == 8'b0010_0000, "R2 at memory", 64'(mem_req_o), 64'h20);
    chk(mem_info_o[5*IW +: IW] == 8'hC3, "R3 bundle at port 5", 64'(mem_info_o[5*IW +: IW]), 64'hC3);
    chk(busy_o == '0, "R2 busy not yet", 64'(busy_o), 64'(0));
    @(negedge clk); req_i = '0; mem_busy_i = 8'b0010_0000;
    @(posedge clk); #1;
    chk(busy_o == 8'b0000_1000, "R2/R5 memory busy returned", 64'(busy_o), 64'h08);
    chk(rdata_o[3*RW +: RW] == 8'h9C, "R6 read data", 64'(rdata_o[3*RW +: RW]), 64'h9C);
    @(negedge clk); mem_busy_i = '0;
    @(posedge clk);

    // R4: column 0 priority, sources 0 and 1 to port 0
    idle_pat(); p_req = 8'b0000_0011; apply();
    idle_pat(); p_req = 8'b0000_0010; apply();   // R10: loser retries alone
    chk(busy_o == 8'b0000_0010, "R4 column 0 even wins", 64'(busy_o), 64'h02);
    idle_pat(); apply();
    chk(busy_o == 8'b0000_0000, "R10 retry passes", 64'(busy_o), 64'h00);
    // R4: last column even switch, sources 0 and 2 to port 0
    idle_pat(); p_req = 8'b0000_0101; apply();
    idle_pat(); apply();
    chk(busy_o == 8'b0000_0100, "R4 even switch favours even input", 64'(busy_o), 64'h04);
    // R4: last column odd switch, sources 5 and 7 to port 7
    idle_pat(); p_req = 8'b1010_0000; p_dest[5] = 3'd7; p_dest[7] = 3'd7; apply();
    idle_pat(); apply();
    chk(busy_o == 8'b0010_0000, "R4 odd switch favours odd input", 64'(busy_o), 64'h20);

    // R8: rotate-right permutation is conflict free
    idle_pat(); p_req = '1; rand_info();
    for (int k = 0; k < N; k++) p_dest[k] = LOG_N'((k >> 1) | ((k & 1) << (LOG_N-1)));
    apply();
    chk(mem_req_o == '1, "R8 all ports reached", 64'(mem_req_o), 64'hFF);
    idle_pat(); apply();
    chk(busy_o == '0, "R8 no busy", 64'(busy_o), 64'(0));

    // R9: every lone source/destination pair
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        idle_pat(); p_req[s] = 1'b1; p_dest[s] = LOG_N'(d); rand_info(); apply();
        chk(mem_req_o == N'(1 << d), "R9 lone arrival", 64'(mem_req_o), 64'(1 << d));
        idle_pat(); apply();
        chk(busy_o == '0, "R9 lone not busy", 64'(busy_o), 64'(0));
      end

    // R4/R7: every request mask against every shared destination
    for (int msk = 0; msk < (1 << N); msk++)
      for (int d = 0; d < N; d++) begin
        idle_pat(); p_req = N'(msk); rand_info();
        for (int k = 0; k < N; k++) p_dest[k] = LOG_N'(d);
        rng = nxt(rng); p_mask = rng[N-1:0];
        apply();
        chk($countones(mem_req_o) == (msk != 0 ? 1 : 0), "R7 one winner", 64'(mem_req_o), 64'(msk != 0));
      end

    // R3/R5/R6/R10: random back-to-back traffic
    for (int t = 0; t < 2000; t++) begin
      rng = nxt(rng); p_req = rng[N-1:0];
      for (int k = 0; k < N; k++) begin rng = nxt(rng); p_dest[k] = rng[LOG_N-1:0]; end
      rand_info();
      rng = nxt(rng); p_mask = rng[N-1:0] & rng[2*N-1:N];
      apply();
    end
    idle_pat(); apply();
    idle_pat(); apply();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule